// File: doc/BRIEF.md
# Carry-Save Tree Multiplier

This block multiplies two unsigned N-bit operands and delivers the full 2N-bit product. It builds one partial product for each multiplier bit. It then compresses these partial products with layers of 3:2 carry-save rows until only two vectors remain. A single carry-propagate adder sums those two vectors. Carries ripple only in that final adder, so the depth of the compression tree grows with the logarithm of the operand width rather than with the width itself.

At each tree level the vectors are taken in groups of three. Each group becomes a sum vector and a carry vector, and the carry vector is moved one place left. A vector that does not fill a group of three goes unchanged to the next level. Every intermediate vector is 2N bits wide. With the default N of 6, the six partial products need three levels: 6 to 4, 4 to 3, and 3 to 2. An optional output register, selected by parameter, adds one cycle of latency and clears under reset. The final adder is either an explicit ripple chain or a plain add operator, also selected by parameter.

Top module: `csa_mult`

## Requirements
- R1: With the output register enabled (default), `p_o` equals the unsigned product of the `a_i` and `b_i` values sampled at the previous rising clock edge, full 2N bits.
- R2: For a multiplier with a single set bit j (`b_i` = 1 shifted left by j), the product equals `a_i` shifted left by j positions.
- R3: The largest operands (all ones) give (2^N-1)^2 with no carry lost, which is 3969 for N=6.
- R4: A zero on either operand gives a zero product.
- R5: While `rst_ni` is low, `p_o` is zero, and this takes effect without waiting for a clock edge. After reset, a new operand pair shows on `p_o` exactly one clock edge later, and `p_o` holds its old value until that edge.
- R6: For N=6, 45 times 63 yields 2835.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the product register |
| a_i | input | N | Multiplicand, unsigned |
| b_i | input | N | Multiplier, unsigned |
| p_o | output | 2N | Product, unsigned |

## Verification
A table of hand-picked pairs runs first. It holds zero on each side, all-ones on both sides, identity multipliers, powers of two, and operand pairs given in both orders. These separate a lost top carry from a wrong shift of the carry vector, and a dropped leftover vector from a bad regrouping. Every one of the 4096 operand pairs for N=6 is then compared against a reference multiply, which covers every partial-product bit pattern. Single-bit multipliers at every position isolate the shift of each partial product. Directed tests apply reset in the middle of a run and check that a new result appears only after the next clock edge.

// File: rtl/csa_pkg.sv
package csa_pkg;

   // number of vectors present at the input of tree level lvl
   function automatic int lvl_cnt(input int n, input int lvl);
      int c;
      c = n;
      for (int k = 0; k < lvl; k++) c = 2 * (c / 3) + (c % 3);
      return c;
   endfunction

   // number of 3:2 levels needed to reach two vectors
   function automatic int num_levels(input int n);
      int c;
      int l;
      c = n;
      l = 0;
      while (c > 2) begin
         c = 2 * (c / 3) + (c % 3);
         l++;
      end
      return l;
   endfunction

endpackage

// File: rtl/csa_pp_gen.sv
module csa_pp_gen #(
   parameter int N  = 6,
   parameter int PW = 2 * N
) (
   input  logic [N-1:0]         a_i,
   input  logic [N-1:0]         b_i,
   output logic [N-1:0][PW-1:0] pp_o
);
   for (genvar j = 0; j < N; j++) begin : g_pp
      assign pp_o[j] = PW'(a_i & {N{b_i[j]}}) << j;
   end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
   parameter int W = 12
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] z_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cry_o
);
   logic [W-2:0] maj;

   assign sum_o = x_i ^ y_i ^ z_i;
   assign maj   = (x_i[W-2:0] & y_i[W-2:0]) |
                  (x_i[W-2:0] & z_i[W-2:0]) |
                  (y_i[W-2:0] & z_i[W-2:0]);
   assign cry_o = {maj, 1'b0};
endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
   parameter int W    = 12,
   parameter int KIND = 0   // 0: explicit ripple chain, 1: add operator
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] s_o
);
   if (KIND == 0) begin : g_ripple
      logic [W-1:0] c;
      assign c[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign s_o[i] = x_i[i] ^ y_i[i] ^ c[i];
         if (i < W - 1) begin : g_c
            assign c[i+1] = (x_i[i] & y_i[i]) | (c[i] & (x_i[i] ^ y_i[i]));
         end
      end
   end else begin : g_op
      assign s_o = x_i + y_i;
   end
endmodule

// File: rtl/csa_mult.sv
module csa_mult #(
   parameter int N          = 6,
   parameter bit REG_OUT    = 1'b1,
   parameter int ADDER_KIND = 0
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [N-1:0]   a_i,
   input  logic [N-1:0]   b_i,
   output logic [2*N-1:0] p_o
);
   localparam int PW = 2 * N;
   localparam int LV = csa_pkg::num_levels(N);

   if (N < 3) begin : g_chk_n
      $error("csa_mult: N must be at least 3");
   end
   if (ADDER_KIND != 0 && ADDER_KIND != 1) begin : g_chk_kind
      $error("csa_mult: ADDER_KIND must be 0 or 1");
   end
   if (N == 6 && LV != 3) begin : g_chk_lv
      $error("csa_mult: six partial products must take three levels");
   end

   logic [N-1:0][PW-1:0] pp;
   logic [PW-1:0]        prod;

   csa_pp_gen #(.N(N), .PW(PW)) pp_i (.a_i(a_i), .b_i(b_i), .pp_o(pp));

   for (genvar gl = 0; gl < LV; gl++) begin : lvl
      localparam int IN   = csa_pkg::lvl_cnt(N, gl);
      localparam int NG   = IN / 3;
      localparam int NR   = IN % 3;
      localparam int NOUT = 2 * NG + NR;

      logic [IN-1:0][PW-1:0]   in_v;
      logic [NOUT-1:0][PW-1:0] out_v;

      if (gl == 0) begin : g_src_pp
         assign in_v = pp;
      end else begin : g_src_lvl
         assign in_v = lvl[gl-1].out_v;
      end

      for (genvar gg = 0; gg < NG; gg++) begin : g_grp
         csa_row #(.W(PW)) row_i (
            .x_i  (in_v[3*gg]),
            .y_i  (in_v[3*gg+1]),
            .z_i  (in_v[3*gg+2]),
            .sum_o(out_v[2*gg]),
            .cry_o(out_v[2*gg+1])
         );
      end
      for (genvar gr = 0; gr < NR; gr++) begin : g_pass
         assign out_v[2*NG+gr] = in_v[3*NG+gr];
      end
   end

   csa_cpa #(.W(PW), .KIND(ADDER_KIND)) cpa_i (
      .x_i(lvl[LV-1].out_v[0]),
      .y_i(lvl[LV-1].out_v[1]),
      .s_o(prod)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) p_o <= '0;
         else         p_o <= prod;
      end
   end else begin : g_comb
      assign p_o = prod;
   end
endmodule

// File: rtl/csa_mult_chk.sv
module csa_mult_chk #(
   parameter int N       = 6,
   parameter bit REG_OUT = 1'b1
) (
   input logic           clk_i,
   input logic           rst_ni,
   input logic [N-1:0]   a_i,
   input logic [N-1:0]   b_i,
   input logic [2*N-1:0] p_o
);
   localparam int            PW   = 2 * N;
   localparam logic [PW-1:0] PMAX = PW'(((2 ** N) - 1) * ((2 ** N) - 1));

   if (REG_OUT) begin : g_seq
      a_r1_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
         1'b1 |=> p_o == PW'($past(a_i)) * PW'($past(b_i)));

      a_r2_unit_multiplier: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (b_i == N'(1)) |=> p_o == PW'($past(a_i)));

      a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (&a_i && &b_i) |=> p_o == PMAX);

      a_r4_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (a_i == '0 || b_i == '0) |=> p_o == '0);

      always @(negedge clk_i) begin
         if (!rst_ni) begin
            a_r5_reset_clear: assert (p_o == '0);
         end
      end
   end else begin : g_comb
      always @(negedge clk_i) begin
         a_r1_comb_product: assert (p_o == PW'(a_i) * PW'(b_i));
      end
   end
endmodule

bind csa_mult csa_mult_chk #(.N(N), .REG_OUT(REG_OUT)) chk_i (
   .clk_i (clk_i),
   .rst_ni(rst_ni),
   .a_i   (a_i),
   .b_i   (b_i),
   .p_o   (p_o)
);

// File: tb/csa_mult_tb.sv
module csa_mult_tb_top;
   localparam int N  = 6;
   localparam int PW = 2 * N;
   localparam int NV = 12;

   // operand A, operand B, expected product
   localparam int TA [NV] = '{45,  0, 37, 63,  1, 63, 13, 21,   32, 17, 42, 7};
   localparam int TB [NV] = '{63, 37,  0, 63, 63,  1, 11, 42,   32,  3, 21, 9};
   localparam int TP [NV] = '{2835, 0, 0, 3969, 63, 63, 143, 882, 1024, 51, 882, 63};

   logic          clk = 1'b0;
   logic          rst_ni = 1'b0;
   logic [N-1:0]  a_i = '0;
   logic [N-1:0]  b_i = '0;
   logic [PW-1:0] p_o;
   int            total = 0;
   int            bad = 0;

   always #2.5 clk = ~clk;

   csa_mult #(.N(N)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .p_o(p_o)
   );

   task automatic check(input string req, input logic [PW-1:0] exp);
      total++;
      if (p_o !== exp) begin
         bad++;
         $display("FAIL %s: a=%0d b=%0d got=%0d expected=%0d", req, a_i, b_i, p_o, exp);
      end
   endtask

   task automatic apply(input int a, input int b);
      @(negedge clk);
      a_i = N'(a);
      b_i = N'(b);
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, got=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R5: reset state
      a_i = 6'd45;
      b_i = 6'd63;
      repeat (3) @(negedge clk);
      check("R5 reset", '0);
      rst_ni = 1'b1;

      // table walk: R1, R3, R4, R6 entries
      for (int k = 0; k < NV; k++) begin
         apply(TA[k], TB[k]);
         if (k == 0)                     check("R6 45x63", PW'(TP[k]));
         else if (TA[k] == 0 || TB[k] == 0) check("R4 zero", PW'(TP[k]));
         else if (k == 3)                check("R3 max", PW'(TP[k]));
         else                            check("R1 table", PW'(TP[k]));
      end

      // R2: single set multiplier bit at every position
      for (int j = 0; j < N; j++) begin
         apply(45, 1 << j);
         check("R2 shift", PW'(45) << j);
         apply(63, 1 << j);
         check("R2 shift", PW'(63) << j);
      end

      // R1: every operand pair against a reference multiply
      for (int a = 0; a < (1 << N); a++) begin
         for (int b = 0; b < (1 << N); b++) begin
            apply(a, b);
            check("R1 exhaustive", PW'(a * b));
         end
      end

      // R5: one-edge latency, old value held until the edge
      apply(45, 63);
      check("R5 latency", PW'(2835));
      @(negedge clk);
      a_i = 6'd13;
      b_i = 6'd11;
      #1;
      check("R5 hold", PW'(2835));
      @(negedge clk);
      check("R5 latency", PW'(143));

      // R5: reset in mid run clears without a clock edge
      apply(63, 63);
      check("R3 max", PW'(3969));
      #0.5;
      rst_ni = 1'b0;
      #0.5;
      check("R5 async reset", '0);
      @(negedge clk);
      check("R5 reset held", '0);
      rst_ni = 1'b1;
      @(negedge clk);
      check("R3 after reset", PW'(3969));

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule